// File: doc/BRIEF.md
# Prescaled Modulo Up-Counter Timer

This block is a 16-bit up-counting timer that software programs through a small 32-bit register port. It has a clock-gating selector and a power-of-two prescaler. Once running, the count starts at a programmable start value and climbs to a programmable wrap limit. On the tick after the limit it returns to the start value and raises a sticky wrap flag. An interrupt line follows the flag whenever the interrupt enable is set.

The wrap limit and the start value are double-buffered. Software writes go to a shadow copy. The copy reaches the counting logic only while the count clock is switched off. Software therefore changes the period by stopping the timer, loading the new values and restarting it. A write of any data to the count register moves the counter to the active start value. That gives a clean start of the period.

The register port takes a word index of two bits. It has a write strobe with write data, and a read data output that is combinational on the index.

Top module: `pmt_timer`

## Requirements
- R1: While running, the counter goes up by one on each prescaled tick. On the tick where it equals the active wrap limit it loads the active start value instead, so one period lasts (limit - start + 1) ticks.
- R2: The wrap flag (control bit 7) is set on the same tick that reloads the start value, and it then stays set.
- R3: A write of any data to the count register (word index 1) loads the counter with the active start value at that clock edge. This overrides a tick in the same cycle, and that tick causes no wrap.
- R4: Writes to the wrap limit (index 2) and the start value (index 3) land in shadow copies, and reads of these indexes return the shadow copies. The active values take the shadow copies only on clock edges where the count clock is off.
- R5: The count clock runs only when the clock-select field (control bits [4:3]) equals 1. With any other value (0, 2 or 3) the counter holds its value.
- R6: The prescaler field (control bits [2:0]) divides the clock by 2^field, so a tick occurs every 2^field cycles, up to 128. A control write that changes the clock-select or prescaler field restarts the divider, and the first tick then comes a full 2^field cycles after that write.
- R7: The interrupt output is high exactly when the wrap flag and the interrupt enable (control bit 6) are both set.
- R8: A control write with bit 7 at 0 clears the wrap flag, and with bit 7 at 1 it leaves the flag unchanged. If a wrap occurs in the same cycle as a clearing write, the flag stays set.
- R9: The register map is index 0 control, 1 count, 2 wrap limit, 3 start value. Only the low 16 bits of the count, limit and start registers are kept. Control bit 5 and bits [31:8] read as zero, and bits [31:16] of the other registers read as zero.
- R10: After reset the control, count, limit and start registers all read zero, and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected index |
| irq | output | 1 | Wrap interrupt request |

## Verification
A wrong active limit or start value shows up as a period of the wrong length. The flag then rises too early or too late, and the bench measures this to the exact cycle after a count write. A divider that keeps stale phase, or fails to reset, moves the first count step and the first wrap away from 2^field cycles. A lost flag or a wrong flag arbitration shows on the next read of the control register and on irq in the same cycle. Shadow-copy mistakes show as a period that changes while the timer is still running, or that keeps its old value after a stop and restart.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    localparam int DATA_W_DEF = 32;
    localparam int CNT_W_DEF  = 16;
    localparam int PS_W       = 3;
    localparam int PS_MAX     = 7;
    localparam int DIV_W      = PS_MAX;
    localparam int CTRL_W     = 8;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_MOD  = 2'd2,
        SEL_INIT = 2'd3
    } reg_sel_e;

    localparam logic [1:0] CSEL_RUN = 2'd1;

    typedef struct packed {
        logic            tof;
        logic            toie;
        logic            rsv;
        logic [1:0]      csel;
        logic [PS_W-1:0] ps;
    } ctrl_t;

    // Terminal value of the divider for a given prescaler field: 2^ps - 1
    function automatic logic [DIV_W-1:0] div_limit(input logic [PS_W-1:0] ps);
        logic [DIV_W-1:0] lim;
        lim = '0;
        for (int i = 0; i < DIV_W; i++) begin
            if (i < int'(ps)) lim[i] = 1'b1;
        end
        return lim;
    endfunction

endpackage

// File: rtl/pmt_regs.sv
module pmt_regs
    import pmt_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ovf,
    output ctrl_t             ctrl,
    output logic              run,
    output logic              restart,
    output logic              ctrl_wr,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  mod_buf,
    output logic [CNT_W-1:0]  init_buf,
    output logic [CNT_W-1:0]  mod_act,
    output logic [CNT_W-1:0]  init_act
);

    ctrl_t wr_ctrl;

    always_comb begin
        wr_ctrl = ctrl_t'(wdata[CTRL_W-1:0]);
        ctrl_wr = we && (addr == SEL_CTRL);
        cnt_wr  = we && (addr == SEL_CNT);
        run     = (ctrl.csel == CSEL_RUN);
        restart = ctrl_wr && ((wr_ctrl.csel != ctrl.csel) || (wr_ctrl.ps != ctrl.ps));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            mod_buf  <= '0;
            init_buf <= '0;
            mod_act  <= '0;
            init_act <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl.csel <= wr_ctrl.csel;
                ctrl.ps   <= wr_ctrl.ps;
                ctrl.toie <= wr_ctrl.toie;
            end
            // a wrap in the same cycle beats a clearing write
            if (ovf)
                ctrl.tof <= 1'b1;
            else if (ctrl_wr && !wr_ctrl.tof)
                ctrl.tof <= 1'b0;

            if (we && addr == SEL_MOD)  mod_buf  <= wdata[CNT_W-1:0];
            if (we && addr == SEL_INIT) init_buf <= wdata[CNT_W-1:0];

            // shadow copies reach the counting logic only while stopped
            if (!run) begin
                mod_act  <= mod_buf;
                init_act <= init_buf;
            end
        end
    end

endmodule

// File: rtl/pmt_prescaler.sv
module pmt_prescaler
    import pmt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            restart,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim  = div_limit(ps);
        tick = run && !restart && (div_q == lim);
    end

    always_ff @(posedge clk) begin
        if (rst || restart || !run || tick)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

endmodule

// File: rtl/pmt_counter.sv
module pmt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] limit,
    input  logic [CNT_W-1:0] start,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    logic at_limit;

    always_comb begin
        at_limit = (cnt == limit);
        ovf      = tick && !load && at_limit;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= start;
        else if (tick)
            cnt <= at_limit ? start : cnt + 1'b1;
    end

endmodule

// File: rtl/pmt_timer.sv
module pmt_timer
    import pmt_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    localparam int CNT_PAD  = DATA_W - CNT_W;
    localparam int CTRL_PAD = DATA_W - CTRL_W;

    ctrl_t            ctrl;
    logic             run;
    logic             restart;
    logic             ctrl_wr;
    logic             cnt_wr;
    logic             tick;
    logic             ovf;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mod_buf;
    logic [CNT_W-1:0] init_buf;
    logic [CNT_W-1:0] mod_act;
    logic [CNT_W-1:0] init_act;

    pmt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .ovf      (ovf),
        .ctrl     (ctrl),
        .run      (run),
        .restart  (restart),
        .ctrl_wr  (ctrl_wr),
        .cnt_wr   (cnt_wr),
        .mod_buf  (mod_buf),
        .init_buf (init_buf),
        .mod_act  (mod_act),
        .init_act (init_act)
    );

    pmt_prescaler u_presc (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (restart),
        .ps      (ctrl.ps),
        .tick    (tick)
    );

    pmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .load  (cnt_wr),
        .limit (mod_act),
        .start (init_act),
        .cnt   (cnt),
        .ovf   (ovf)
    );

    always_comb begin
        unique case (reg_addr)
            SEL_CTRL: reg_rdata = {{CTRL_PAD{1'b0}}, ctrl.tof, ctrl.toie, 1'b0, ctrl.csel, ctrl.ps};
            SEL_CNT:  reg_rdata = {{CNT_PAD{1'b0}}, cnt};
            SEL_MOD:  reg_rdata = {{CNT_PAD{1'b0}}, mod_buf};
            default:  reg_rdata = {{CNT_PAD{1'b0}}, init_buf};
        endcase
        irq = ctrl.tof && ctrl.toie;
    end

endmodule

module pmt_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             run,
    input logic             ovf,
    input logic             cnt_wr,
    input logic             ctrl_wr,
    input logic             wr_tof,
    input logic             tof,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] mod_act,
    input logic [CNT_W-1:0] init_act
);

    assert_wrap_reload_R1: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && cnt == mod_act) |=> (cnt == $past(init_act)));

    assert_flag_on_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        ovf |=> tof);

    assert_count_load_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt == $past(init_act)));

    assert_limit_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        run |=> (mod_act == $past(mod_act) && init_act == $past(init_act)));

    assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> (cnt == $past(cnt)));

    assert_tick_needs_run_R6: assert property (@(posedge clk) disable iff (rst)
        tick |-> run);

    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> tof);

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !wr_tof && !ovf) |=> !tof);

endmodule

bind pmt_timer pmt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .run      (run),
    .ovf      (ovf),
    .cnt_wr   (cnt_wr),
    .ctrl_wr  (ctrl_wr),
    .wr_tof   (reg_wdata[7]),
    .tof      (ctrl.tof),
    .irq      (irq),
    .cnt      (cnt),
    .mod_act  (mod_act),
    .init_act (init_act)
);

// File: tb/test_pmt_timer.sv
`timescale 1ns/1ps
module test_pmt_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CNT  = 2'd1;
    localparam logic [1:0] A_MOD  = 2'd2;
    localparam logic [1:0] A_INIT = 2'd3;

    always #4 clk = ~clk;

    pmt_timer i_pmt_timer (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] flag_of(input logic [31:0] c);
        return {31'd0, c[7]};
    endfunction

    // reload counter, clear flag, then expect the flag exactly p edges after the reload
    task automatic measure(input string req, input int p, input logic [31:0] ctrl_fields);
        logic [31:0] d;
        wr(A_CNT, 32'h0);
        wr(A_CTRL, ctrl_fields & 32'h7F);
        rd(A_CTRL, d); check({req, " flag cleared"}, flag_of(d), 0);
        waitn(p - 2);
        rd(A_CTRL, d); check({req, " no wrap before period"}, flag_of(d), 0);
        waitn(1);
        rd(A_CTRL, d); check({req, " wrap at period"}, flag_of(d), 1);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(A_CTRL, d); check("R10 ctrl", d, 0);
        rd(A_CNT, d);  check("R10 count", d, 0);
        rd(A_MOD, d);  check("R10 limit", d, 0);
        rd(A_INIT, d); check("R10 start", d, 0);
        check("R10 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_map;
        logic [31:0] d;
        wr(A_MOD, 32'hFFFF_FFFF);
        rd(A_MOD, d); check("R9 limit width", d, 32'h0000_FFFF);
        wr(A_INIT, 32'hABCD_1234);
        rd(A_INIT, d); check("R9 start width", d, 32'h0000_1234);
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, d); check("R9 ctrl unused bits", d, 32'h0000_005F);
        waitn(5);
        rd(A_CNT, d); check("R5 select 3 holds", d, 0);
        wr(A_CTRL, 32'h0000_0010);
        waitn(4);
        rd(A_CNT, d); check("R5 select 2 holds", d, 0);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_basic;
        logic [31:0] d;
        wr(A_INIT, 32'd2);
        wr(A_MOD, 32'd5);
        wr(A_CNT, 32'hDEAD_BEEF);
        rd(A_CNT, d); check("R3 count write loads start", d, 2);
        wr(A_CTRL, 32'h08);
        rd(A_CNT, d); check("R6 no step on enable edge", d, 2);
        waitn(3);
        rd(A_CNT, d); check("R1 reaches limit", d, 5);
        rd(A_CTRL, d); check("R2 no flag at limit", flag_of(d), 0);
        waitn(1);
        rd(A_CNT, d); check("R1 reload start", d, 2);
        rd(A_CTRL, d); check("R2 flag on reload", flag_of(d), 1);
        waitn(3);
        rd(A_CTRL, d); check("R2 flag sticky", flag_of(d), 1);
    endtask

    task automatic t_flag;
        logic [31:0] d;
        wr(A_CNT, 32'h0);
        wr(A_CTRL, 32'h88);
        rd(A_CTRL, d); check("R8 write one keeps flag", flag_of(d), 1);
        wr(A_CTRL, 32'h08);
        rd(A_CTRL, d); check("R8 write zero clears", flag_of(d), 0);
        // count write at C, the clear above at C+2, wrap due at C+4
        waitn(1);
        wr(A_CTRL, 32'h08);
        rd(A_CTRL, d); check("R8 wrap beats clear", flag_of(d), 1);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        check("R7 irq off with enable clear", {31'd0, irq}, 0);
        wr(A_CTRL, 32'hC8);
        check("R7 irq with flag and enable", {31'd0, irq}, 1);
        rd(A_CTRL, d); check("R9 enable bit 6", d & 32'h40, 32'h40);
        wr(A_CNT, 32'h0);
        wr(A_CTRL, 32'h48);
        check("R7 irq drops with flag", {31'd0, irq}, 0);
        wr(A_CTRL, 32'h08);
    endtask

    task automatic t_buffer;
        logic [31:0] d;
        logic [31:0] held;
        wr(A_MOD, 32'd9);
        rd(A_MOD, d); check("R4 shadow readback", d, 9);
        measure("R4 old limit while running", 4, 32'h08);
        wr(A_CTRL, 32'h00);
        rd(A_CNT, held);
        waitn(3);
        rd(A_CNT, d); check("R5 select 0 holds", d, held);
        wr(A_CTRL, 32'h08);
        measure("R4 new limit after stop", 8, 32'h08);
    endtask

    task automatic t_prescale;
        logic [31:0] d;
        wr(A_CTRL, 32'h00);
        wr(A_INIT, 32'd0);
        wr(A_MOD, 32'd1);
        wr(A_CNT, 32'h0);
        wr(A_CTRL, 32'h0A);
        waitn(3);
        rd(A_CNT, d); check("R6 no step before 4 cycles", d, 0);
        waitn(1);
        rd(A_CNT, d); check("R6 step at 4 cycles", d, 1);
        waitn(3);
        rd(A_CTRL, d); check("R6 no wrap before 8", flag_of(d), 0);
        waitn(1);
        rd(A_CTRL, d); check("R6 wrap at 8", flag_of(d), 1);
        rd(A_CNT, d); check("R6 count back to start", d, 0);
        // change the prescaler while running: divider restarts
        waitn(1);
        wr(A_CNT, 32'h0);
        wr(A_CTRL, 32'h03 | 32'h08);
        waitn(7);
        rd(A_CNT, d); check("R6 restart no early step", d, 0);
        waitn(1);
        rd(A_CNT, d); check("R6 restart step at 8", d, 1);
        wr(A_CTRL, 32'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_map();
        t_basic();
        t_flag();
        t_irq();
        t_buffer();
        t_prescale();
        waitn(2);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule